// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a 32x32 cursor over a stream of 24-bit pixels. Each pixel arrives with its beam coordinates. When the beam lies inside the cursor box, the block looks up the matching cursor entry in a local image memory and chooses one of three actions. It can leave the background alone, paint a fixed colour, or invert the background. The result leaves the block one clock after the pixel entered. Software loads the image memory one 16-bit word at a time, sets the cursor position through a packed position word, and turns the overlay on or off with a control bit.

A new position is not used straight away. It is held as pending and adopted on the first pixel of the next frame, which is the pixel at beam (0,0). Moving the cursor while the beam is crossing its rows therefore never tears the frame on screen. The enable bit is different: it takes effect on the clock after it is written.

Top module: `hwcur_overlay`

## Requirements
- R1: `outValid` equals `pixValid` delayed by exactly one clock, and `outPix` carries the result for the pixel presented one clock earlier. While `pixValid` is low, `outPix` holds its value.
- R2: A cursor entry of 0x0000 is transparent, so the background pixel passes unchanged.
- R3: An entry with bit 15 set is opaque. Its colour is taken from bits 14:10 (red), 9:5 (green) and 4:0 (blue). Each 5-bit channel c becomes {c, c[4:2]}. The output is {red, green, blue} in bits 23:16, 15:8 and 7:0. For example, 0xFFFF gives 0xFFFFFF and 0x8000 gives 0x000000.
- R4: An entry with bit 15 clear and a non-zero bits 14:0 inverts the background. The output is the bitwise NOT of all 24 bits; 0x7FFF is one such entry.
- R5: Let dx = beamX - X and dy = beamY - Y. The cursor covers a pixel only when both dx and dy lie in 0..31. The entry used is dy*32 + dx. Every pixel outside the box passes unchanged, including the pixels of a cursor cut off at the right or bottom screen edge.
- R6: In the position word, X is taken from bits 11:0 and Y from bits 27:16.
- R7: A position write becomes pending. It is applied on the next valid pixel at beam (0,0), and that pixel already uses the new position. Pixels before that point, including the rest of the current frame, keep using the old position.
- R8: Bit 0 of the control word enables the overlay and takes effect on the next clock. While it is 0, every pixel passes unchanged.
- R9: After reset, `outValid` and `outPix` are 0, the overlay is disabled, and the position is (0,0) with nothing pending.
- R10: A write with `imgWrEn` stores `imgData` at image index `imgAddr`, where the index is row*32 + column. Later pixels that hit that entry use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Strobe to write the control word |
| ctlData | input | 8 | Control word; bit 0 is the overlay enable |
| posWrEn | input | 1 | Strobe to write a pending cursor position |
| posData | input | 32 | Position word: X in 11:0, Y in 27:16 |
| imgWrEn | input | 1 | Strobe to write one cursor image entry |
| imgAddr | input | 10 | Image index, row*32 + column |
| imgData | input | 16 | Image entry: bit 15 opaque flag, bits 14:0 colour |
| pixValid | input | 1 | Pixel on the stream inputs is valid |
| beamX | input | 12 | Beam column of the incoming pixel |
| beamY | input | 12 | Beam row of the incoming pixel |
| bgPix | input | 24 | Background pixel, RGB 8:8:8 |
| outValid | output | 1 | Output pixel is valid |
| outPix | output | 24 | Pixel after the overlay |

## Verification
A wrong box offset or a swapped row/column index shows up at the output as a cursor image that is shifted or transposed. The bench catches it on the very next clock after the first pixel that reaches the wrong entry. If the pending position is applied at the wrong moment, pixels after a mid-frame position write are painted at the new place within the same frame, and the first mismatch appears one clock after the beam enters the old or the new box. A wrong decode of the opaque flag or of the colour fields shows up as a wrong colour or a wrongly inverted pixel, one clock after any box pixel that uses that kind of entry.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

  // log2 of the cursor side length in pixels (32x32 cursor)
  localparam int unsigned CurSideLog2 = 5;
  localparam int unsigned CurAddrW    = 2 * CurSideLog2;
  localparam int unsigned EntryW      = 16;
  localparam int unsigned ChanW       = 5;
  localparam int unsigned PixChanW    = 8;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic                hit;     // pixel lies inside an enabled cursor box
    logic [CurAddrW-1:0] memIdx;  // image index {row, column}
  } cur_stb_t;

endpackage

// File: rtl/hwcur_ctrl.sv
module hwcur_ctrl
  import hwcur_pkg::*;
#(
  parameter int unsigned CoordW = 12,
  parameter int unsigned PosYLsb = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlData,
  input  logic              posWrEn,
  input  logic [31:0]       posData,
  input  logic              pixValid,
  input  logic [CoordW-1:0] beamX,
  input  logic [CoordW-1:0] beamY,
  output cur_stb_t          stb
);

  localparam int unsigned IdxW  = CurSideLog2;
  localparam int unsigned DiffW = CoordW + 1;

  logic              enReg;
  logic [CoordW-1:0] curX, curY, pendX, pendY;
  logic              pendValid;

  logic              atOrigin, takePend;
  logic [CoordW-1:0] effX, effY;
  logic [DiffW-1:0]  dx, dy;
  logic              inX, inY;

  logic unusedCtlBits;
  assign unusedCtlBits = ^{ctlData[7:1], posData[31:PosYLsb+CoordW],
                           posData[PosYLsb-1:CoordW]};

  // The first pixel of a frame is the safe point for a position change
  assign atOrigin = pixValid && (beamX == '0) && (beamY == '0);
  assign takePend = atOrigin && pendValid;

  assign effX = takePend ? pendX : curX;
  assign effY = takePend ? pendY : curY;

  assign dx = {1'b0, beamX} - {1'b0, effX};
  assign dy = {1'b0, beamY} - {1'b0, effY};

  assign inX = !dx[DiffW-1] && (dx[CoordW-1:IdxW] == '0);
  assign inY = !dy[DiffW-1] && (dy[CoordW-1:IdxW] == '0);

  always_comb begin
    stb.hit    = enReg && inX && inY;
    stb.memIdx = {dy[IdxW-1:0], dx[IdxW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enReg     <= 1'b0;
      curX      <= '0;
      curY      <= '0;
      pendX     <= '0;
      pendY     <= '0;
      pendValid <= 1'b0;
    end else begin
      if (ctlWrEn) enReg <= ctlData[0];
      if (takePend) begin
        curX <= pendX;
        curY <= pendY;
      end
      if (posWrEn) begin
        pendX     <= posData[CoordW-1:0];
        pendY     <= posData[PosYLsb+CoordW-1:PosYLsb];
        pendValid <= 1'b1;
      end else if (takePend) begin
        pendValid <= 1'b0;
      end
    end
  end

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !takePend |=> ($stable(curX) && $stable(curY)));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (takePend && !posWrEn) |=> !pendValid);

  // R6
  pos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    posWrEn |=> (pendValid && pendX == $past(posData[CoordW-1:0])
                 && pendY == $past(posData[PosYLsb+CoordW-1:PosYLsb])));

  // R8
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWrEn |=> (enReg == $past(ctlData[0])));

endmodule

// File: rtl/hwcur_datapath.sv
module hwcur_datapath
  import hwcur_pkg::*;
#(
  parameter int unsigned PixW = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                imgWrEn,
  input  logic [CurAddrW-1:0] imgAddr,
  input  logic [EntryW-1:0]   imgData,
  input  logic                pixValid,
  input  logic [PixW-1:0]     bgPix,
  input  cur_stb_t            stb,
  output logic                outValid,
  output logic [PixW-1:0]     outPix
);

  localparam int unsigned Depth  = 1 << CurAddrW;
  localparam int unsigned NumChn = 3;

  logic [EntryW-1:0] img [Depth];
  logic [EntryW-1:0] entry;
  logic              isOpaque, isInvert;
  logic [PixW-1:0]   expanded;
  logic [PixW-1:0]   nextPix;

  always_ff @(posedge clk) begin
    if (imgWrEn) img[imgAddr] <= imgData;
  end

  assign entry    = img[stb.memIdx];
  assign isOpaque = entry[EntryW-1];
  assign isInvert = !entry[EntryW-1] && (entry[EntryW-2:0] != '0);

  // Widen each 5-bit channel to 8 bits by repeating its top bits
  for (genvar ch = 0; ch < NumChn; ch++) begin : g_chan
    logic [ChanW-1:0] c5;
    assign c5 = entry[ch*ChanW +: ChanW];
    assign expanded[ch*PixChanW +: PixChanW] =
      {c5, c5[ChanW-1 -: (PixChanW-ChanW)]};
  end

  always_comb begin
    nextPix = bgPix;
    if (stb.hit) begin
      if (isOpaque)      nextPix = expanded;
      else if (isInvert) nextPix = ~bgPix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= pixValid;
      if (pixValid) outPix <= nextPix;
    end
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (outValid == $past(pixValid)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |=> $stable(outPix));

  // R5
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && !stb.hit) |=> (outPix == $past(bgPix)));

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && stb.hit && isInvert) |=> ((outPix ^ $past(bgPix)) == '1));

  // R3
  opaque_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && stb.hit && isOpaque) |=>
      (outPix[PixW-1 -: ChanW] == $past(entry[EntryW-2 -: ChanW])));

endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int unsigned CoordW = 12,
  parameter int unsigned PixW   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctlWrEn,
  input  logic [7:0]          ctlData,
  input  logic                posWrEn,
  input  logic [31:0]         posData,
  input  logic                imgWrEn,
  input  logic [CurAddrW-1:0] imgAddr,
  input  logic [EntryW-1:0]   imgData,
  input  logic                pixValid,
  input  logic [CoordW-1:0]   beamX,
  input  logic [CoordW-1:0]   beamY,
  input  logic [PixW-1:0]     bgPix,
  output logic                outValid,
  output logic [PixW-1:0]     outPix
);

  cur_stb_t stb;

  hwcur_ctrl #(.CoordW(CoordW), .PosYLsb(16)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctlWrEn  (ctlWrEn),
    .ctlData  (ctlData),
    .posWrEn  (posWrEn),
    .posData  (posData),
    .pixValid (pixValid),
    .beamX    (beamX),
    .beamY    (beamY),
    .stb      (stb)
  );

  hwcur_datapath #(.PixW(PixW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .imgWrEn  (imgWrEn),
    .imgAddr  (imgAddr),
    .imgData  (imgData),
    .pixValid (pixValid),
    .bgPix    (bgPix),
    .stb      (stb),
    .outValid (outValid),
    .outPix   (outPix)
  );

endmodule

// File: tb/sim_hwcur_overlay.sv
module sim_hwcur_overlay;

  localparam int ScrW = 48;
  localparam int ScrH = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [7:0]  ctlData = '0;
  logic        posWrEn = 1'b0;
  logic [31:0] posData = '0;
  logic        imgWrEn = 1'b0;
  logic [9:0]  imgAddr = '0;
  logic [15:0] imgData = '0;
  logic        pixValid = 1'b0;
  logic [11:0] beamX = '0;
  logic [11:0] beamY = '0;
  logic [23:0] bgPix = '0;
  logic        outValid;
  logic [23:0] outPix;

  hwcur_overlay u0 (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlData(ctlData),
    .posWrEn(posWrEn), .posData(posData), .imgWrEn(imgWrEn),
    .imgAddr(imgAddr), .imgData(imgData), .pixValid(pixValid),
    .beamX(beamX), .beamY(beamY), .bgPix(bgPix),
    .outValid(outValid), .outPix(outPix)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int nComp = 0;
  int nBad  = 0;
  bit done  = 0;

  // Reference model state
  logic [15:0] mImg [1024];
  bit    mEn = 0;
  int    mCurX = 0, mCurY = 0, mPendX = 0, mPendY = 0;
  bit    mPend = 0;
  string phase = "R9";

  // Scoreboard queues
  logic [23:0] expQ [$];
  string       tagQ [$];
  int          cycQ [$];

  function automatic logic [7:0] widen(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [15:0] pattern(input int i);
    case (i % 5)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      default: return (i % 2 == 1) ? (16'h8000 | 16'((i * 173) & 16'h7FFF))
                                   : (16'((i * 91) & 16'h7FFF) | 16'h0001);
    endcase
  endfunction

  function automatic logic [23:0] bgOf(input int x, input int y);
    return {8'(x * 5), 8'(y * 9), 8'((x ^ y) * 3)};
  endfunction

  task automatic drivePix(input int x, input int y);
    logic [23:0] bg, e24;
    logic [15:0] e;
    string tag;
    int dx, dy;
    @(negedge clk);
    if (x == 0 && y == 0 && mPend) begin
      mCurX = mPendX; mCurY = mPendY; mPend = 0;
    end
    bg = bgOf(x, y);
    dx = x - mCurX;
    dy = y - mCurY;
    if (!mEn) begin
      tag = "R8"; e24 = bg;
    end else if (dx < 0 || dx > 31 || dy < 0 || dy > 31) begin
      tag = "R5"; e24 = bg;
    end else begin
      e = mImg[dy * 32 + dx];
      if (e[15]) begin
        tag = "R3"; e24 = {widen(e[14:10]), widen(e[9:5]), widen(e[4:0])};
      end else if (e[14:0] != 15'h0) begin
        tag = "R4"; e24 = ~bg;
      end else begin
        tag = "R2"; e24 = bg;
      end
    end
    pixValid = 1'b1;
    beamX = 12'(x);
    beamY = 12'(y);
    bgPix = bg;
    expQ.push_back(e24);
    tagQ.push_back({tag, "/", phase});
    cycQ.push_back(cyc);
  endtask

  task automatic writePos(input int x, input int y);
    @(negedge clk);
    pixValid = 1'b0;
    posWrEn = 1'b1;
    posData = (32'(y) << 16) | 32'(x);
    mPendX = x; mPendY = y; mPend = 1;
    @(negedge clk);
    posWrEn = 1'b0;
  endtask

  task automatic writeCtl(input bit en);
    @(negedge clk);
    pixValid = 1'b0;
    ctlWrEn = 1'b1;
    ctlData = {7'h0, en};
    mEn = en;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic runFrame(input int wrRow, input int nx, input int ny);
    for (int y = 0; y < ScrH; y++) begin
      for (int x = 0; x < ScrW; x++) begin
        if (wrRow >= 0 && y == wrRow && x == 0) writePos(nx, ny);
        drivePix(x, y);
      end
    end
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nComp, nBad);
  endtask

  // Monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rst_n && outValid && !done) begin
      nComp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R1: outValid=1 with nothing expected (actual %h, expected none)", outPix);
      end else begin
        logic [23:0] e;
        string t;
        int c;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        c = cycQ.pop_front();
        if (outPix !== e) begin
          nBad++;
          $display("FAIL %s: outPix actual %h expected %h", t, outPix, e);
        end else if (cyc != c + 1) begin
          nBad++;
          $display("FAIL R1: latency actual %0d expected 1", cyc - c);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL R1: watchdog expired (actual hung, expected completion)");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state at the ports
    nComp++;
    if (outValid !== 1'b0 || outPix !== 24'h0) begin
      nBad++;
      $display("FAIL R9: reset outputs actual %b/%h expected 0/000000", outValid, outPix);
    end

    // R10: load the whole image
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      imgWrEn = 1'b1;
      imgAddr = 10'(i);
      imgData = pattern(i);
      mImg[i] = pattern(i);
    end
    @(negedge clk);
    imgWrEn = 1'b0;

    // R9 R8: disabled after reset, every pixel passes
    writePos(5, 3);
    phase = "R9";
    runFrame(-1, 0, 0);

    // R10 R6: enabled cursor at (5,3) shows the loaded image
    writeCtl(1);
    phase = "R10";
    runFrame(-1, 0, 0);

    // R5: clipped at the right and bottom edges
    writePos(30, 20);
    phase = "R5clip";
    runFrame(-1, 0, 0);
    writePos(40, 35);
    runFrame(-1, 0, 0);

    // R7: move while the beam is inside the cursor rows
    writePos(0, 0);
    phase = "R6";
    runFrame(-1, 0, 0);
    phase = "R7";
    runFrame(5, 10, 8);
    runFrame(-1, 0, 0);

    // R8: disable again
    writeCtl(0);
    phase = "R8";
    runFrame(-1, 0, 0);

    repeat (4) @(negedge clk);
    // R1: every driven pixel came out
    nComp++;
    if (expQ.size() != 0) begin
      nBad++;
      $display("FAIL R1: pending outputs actual %0d expected 0", expQ.size());
    end
    done = 1;
    report();
    $finish;
  end

endmodule